// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block counts down from a loaded start value at a rate set by a power-of-two prescaler and raises an interrupt request each time the count expires. Three write ports program it: the start value, the divide setting and an interrupt entry. The entry carries an 8-bit vector, a mask bit and a mode bit that selects one-shot or periodic operation. The stored settings and the live count can be read back at all times.

A write of the start value reloads the counter and restarts the prescale phase. In one-shot mode the count stops at zero. In periodic mode the counter runs from the start value down to zero, then reloads the start value, so one period spans start+1 ticks. At each expiry the block emits a one-cycle fire pulse that carries the programmed vector, unless the entry is masked. Vector delivery to a priority controller and the bus interface sit outside the block.

Top module: `lcl_timer`

## Requirements
- R1: After reset the count and start-value readbacks are 0, the divide readback is 0, the entry readback is 0x0001_0000 (masked, one-shot, vector 0) and fire_o is low.
- R2: A divide write keeps only bits 0, 1 and 3 of the data. The readback is data & 0xB.
- R3: The divide code is {bit3, bit1, bit0}. The shift is (code + 1) mod 8 and the count steps down once every 2^shift clocks, so code 7 divides by 1 and code 0 divides by 2. A divide write restarts the prescale phase.
- R4: A start-value write puts that value on count_o in the next cycle, updates the start-value readback and restarts the prescale phase. The first decrement comes 2^shift clocks after the write.
- R5: In one-shot mode (entry bit 17 clear) the count stops at 0 and stays there until the next start-value write.
- R6: In periodic mode (entry bit 17 set) the tick that finds the count at 0 reloads the start value.
- R7: fire_o is a single-cycle pulse in the first cycle that count_o shows 0 after stepping down from 1. fire_vec_o then holds entry bits 7:0.
- R8: While entry bit 16 (mask) is set no fire pulse occurs, but counting and reloads go on unchanged.
- R9: A start value of 0 stops the timer. The count stays 0 and no fire pulse occurs, in either mode.
- R10: An entry write stores only bits 7:0, 16 and 17. The readback shows those bits and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_wr | input | 1 | Write strobe for the start value |
| init_wdata | input | 32 | Start value to write |
| div_wr | input | 1 | Write strobe for the divide setting |
| div_wdata | input | 32 | Divide setting to write |
| ent_wr | input | 1 | Write strobe for the interrupt entry |
| ent_wdata | input | 32 | Entry: vector [7:0], mask [16], periodic [17] |
| count_o | output | 32 | Live count |
| init_o | output | 32 | Stored start value |
| div_o | output | 32 | Stored divide setting |
| ent_o | output | 32 | Stored entry |
| fire_o | output | 1 | One-cycle expiry pulse |
| fire_vec_o | output | 8 | Vector that goes with the fire pulse |

## Verification
A wrong prescale phase or a bad divide decode makes count_o step down one or more clocks early or late, so it is caught within 2^shift cycles of the write that caused it. A wrong reload or stop decision gives a count other than the start value or 0 on the tick after zero. A bad fire condition shows as a missing, doubled or unmasked pulse in the cycle the count reaches 0. The bench compares every output in every cycle against its own model, so any such divergence is flagged in the cycle it first appears.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
    localparam int CNT_W   = 32;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int DIV_W   = 4;
    localparam int MASK_BIT = 16;
    localparam int PER_BIT  = 17;
    localparam logic [31:0] DIV_KEEP = 32'h0000_000B;

    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [DIV_W-1:0] div;
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic             per;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             fire;
        logic [VEC_W-1:0] vec;
    } cnt_st_t;

    function automatic logic [SHIFT_W-1:0] shift_of(input logic [DIV_W-1:0] d);
        logic [SHIFT_W-1:0] code;
        code = {d[3], d[1:0]};
        return code + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/tmr_cfg_regs.sv
`timescale 1ns/1ps
module tmr_cfg_regs
    import timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_wr,
    input  logic [31:0] init_wdata,
    input  logic        div_wr,
    input  logic [31:0] div_wdata,
    input  logic        ent_wr,
    input  logic [31:0] ent_wdata,
    output cfg_t        cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (init_wr) cfg_d.init = init_wdata[CNT_W-1:0];
        if (div_wr)  cfg_d.div  = DIV_W'(div_wdata & DIV_KEEP);
        if (ent_wr) begin
            cfg_d.vec  = ent_wdata[VEC_W-1:0];
            cfg_d.mask = ent_wdata[MASK_BIT];
            cfg_d.per  = ent_wdata[PER_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mask <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    assert_div_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.div[2] == 1'b0));
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import timer_pkg::*;
#(
    parameter int SHW = SHIFT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SHW-1:0] shift,
    input  logic           restart,
    output logic           tick
);
    localparam int PW = (1 << SHW) - 1;

    logic [PW-1:0] presc_d, presc_q;
    logic [PW:0]   limit;
    logic [PW-1:0] last;

    always_comb begin
        limit = (PW+1)'(1) << shift;
        last  = PW'(limit - (PW+1)'(1));
        tick  = (presc_q == last);
        if (restart)   presc_d = '0;
        else if (tick) presc_d = '0;
        else           presc_d = presc_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end

    assert_presc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, presc_q} < limit));
    assert_restart_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (presc_q == '0));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_q,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vec,
    output logic [CNT_W-1:0] count_o,
    output logic             fire_o,
    output logic [VEC_W-1:0] vec_o
);
    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (load) begin
            st_d.count = load_val;
        end else if (tick && (init_q != '0)) begin
            if (st_q.count == '0) begin
                if (periodic) st_d.count = init_q;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
                if ((st_q.count == CNT_W'(1)) && !mask) begin
                    st_d.fire = 1'b1;
                    st_d.vec  = vec;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign fire_o  = st_q.fire;
    assign vec_o   = st_q.vec;

    assert_fire_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |=> !st_q.fire);
    assert_fire_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> (st_q.count == '0));
    assert_fire_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> !$past(mask));
    assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && !load && st_q.count == '0) |=> (st_q.count == '0));
    assert_zero_start_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q == '0 && !load) |=> !st_q.fire);
    assert_step_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && st_q.count != '0) |=>
            (st_q.count == $past(st_q.count) || st_q.count == $past(st_q.count) - CNT_W'(1)));
endmodule

// File: rtl/lcl_timer.sv
`timescale 1ns/1ps
module lcl_timer
    import timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_wr,
    input  logic [31:0] init_wdata,
    input  logic        div_wr,
    input  logic [31:0] div_wdata,
    input  logic        ent_wr,
    input  logic [31:0] ent_wdata,
    output logic [31:0] count_o,
    output logic [31:0] init_o,
    output logic [31:0] div_o,
    output logic [31:0] ent_o,
    output logic        fire_o,
    output logic [7:0]  fire_vec_o
);
    cfg_t                cfg;
    logic                tick;
    logic [SHIFT_W-1:0]  shift;
    logic [CNT_W-1:0]    count;

    tmr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .init_wr(init_wr), .init_wdata(init_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .ent_wr(ent_wr), .ent_wdata(ent_wdata),
        .cfg_o(cfg)
    );

    assign shift = shift_of(cfg.div);

    tmr_prescaler #(.SHW(SHIFT_W)) u_presc (
        .clk(clk), .rst_n(rst_n),
        .shift(shift), .restart(init_wr | div_wr),
        .tick(tick)
    );

    tmr_counter u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .load(init_wr), .load_val(init_wdata[CNT_W-1:0]),
        .init_q(cfg.init), .periodic(cfg.per), .mask(cfg.mask), .vec(cfg.vec),
        .count_o(count), .fire_o(fire_o), .vec_o(fire_vec_o)
    );

    always_comb begin
        count_o = 32'(count);
        init_o  = 32'(cfg.init);
        div_o   = 32'(cfg.div);
        ent_o   = '0;
        ent_o[VEC_W-1:0] = cfg.vec;
        ent_o[MASK_BIT]  = cfg.mask;
        ent_o[PER_BIT]   = cfg.per;
    end

    assert_load_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (count_o == $past(init_wdata)));
    assert_entry_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_o & ~32'h0003_00FF) == 32'h0);
endmodule

// File: tb/lcl_timer_bench.sv
`timescale 1ns/1ps
module lcl_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_wr = 1'b0, div_wr = 1'b0, ent_wr = 1'b0;
    logic [31:0] init_wdata = '0, div_wdata = '0, ent_wdata = '0;
    logic [31:0] count_o, init_o, div_o, ent_o;
    logic        fire_o;
    logic [7:0]  fire_vec_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcl_timer u_lcl_timer (
        .clk(clk), .rst_n(rst_n),
        .init_wr(init_wr), .init_wdata(init_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .ent_wr(ent_wr), .ent_wdata(ent_wdata),
        .count_o(count_o), .init_o(init_o), .div_o(div_o), .ent_o(ent_o),
        .fire_o(fire_o), .fire_vec_o(fire_vec_o)
    );

    // model state, as the requirements define it
    logic [31:0] m_init, m_div, m_ent, m_cnt, m_presc;
    logic        m_fire;
    logic [7:0]  m_vec;

    function automatic int div_ratio(input logic [31:0] d);
        int code;
        code = {d[3], d[1], d[0]};
        return 1 << ((code + 1) % 8);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic model_next(input bit wi, input logic [31:0] wid, input bit wd,
                              input logic [31:0] wdd, input bit we, input logic [31:0] wed);
        bit tick;
        tick = (m_presc == 32'(div_ratio(m_div) - 1));
        m_fire = 1'b0;
        if (wi) begin
            m_cnt = wid;
        end else if (tick && m_init != 0) begin
            if (m_cnt == 0) begin
                if (m_ent[17]) m_cnt = m_init;
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0 && !m_ent[16]) begin
                    m_fire = 1'b1;
                    m_vec = m_ent[7:0];
                end
            end
        end
        if (wi || wd || tick) m_presc = 0; else m_presc = m_presc + 1;
        if (wi) m_init = wid;
        if (wd) m_div = wdd & 32'hB;
        if (we) m_ent = wed & 32'h0003_00FF;
    endtask

    task automatic compare_all();
        chk(m_ent[17] ? "R6 count" : "R5 count", count_o, m_cnt);
        chk(m_ent[16] ? "R8 fire" : "R7 fire", 32'(fire_o), 32'(m_fire));
        if (m_fire) chk("R7 vector", 32'(fire_vec_o), 32'(m_vec));
        chk("R4 start readback", init_o, m_init);
        chk("R2 divide readback", div_o, m_div);
        chk("R10 entry readback", ent_o, m_ent);
    endtask

    task automatic cycle(input bit wi, input logic [31:0] wid, input bit wd,
                         input logic [31:0] wdd, input bit we, input logic [31:0] wed);
        init_wr = wi; init_wdata = wid;
        div_wr = wd;  div_wdata = wdd;
        ent_wr = we;  ent_wdata = wed;
        model_next(wi, wid, wd, wdd, we, wed);
        @(posedge clk);
        @(negedge clk);
        init_wr = 1'b0; div_wr = 1'b0; ent_wr = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        m_init = 0; m_div = 0; m_ent = 32'h0001_0000; m_cnt = 0; m_presc = 0;
        m_fire = 0; m_vec = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 start", init_o, 0);
        chk("R1 divide", div_o, 0);
        chk("R1 entry", ent_o, 32'h0001_0000);
        chk("R1 fire", 32'(fire_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 masking of divide data, code 7 gives divide by 1 (R3)
        cycle(0, 0, 1, 32'hFFFF_FFFF, 0, 0);
        chk("R2 keep mask", div_o, 32'h0000_000B);
        // one-shot expiry with vector 0x5A
        cycle(0, 0, 0, 0, 1, 32'h0000_005A);
        cycle(1, 3, 0, 0, 0, 0);
        chk("R4 load", count_o, 3);
        idle(2);
        chk("R3 divide by 1", count_o, 1);
        idle(1);
        chk("R7 fire pulse", 32'(fire_o), 1);
        chk("R7 vector", 32'(fire_vec_o), 32'h5A);
        idle(1);
        chk("R7 pulse ends", 32'(fire_o), 0);
        idle(5);
        chk("R5 stays zero", count_o, 0);

        // code 0 divides by 2 (R3)
        cycle(0, 0, 1, 32'h0, 0, 0);
        cycle(1, 10, 0, 0, 0, 0);
        idle(1);
        chk("R3 no step before ratio", count_o, 10);
        idle(3);
        chk("R3 divide by 2", count_o, 8);

        // periodic reload (R6)
        cycle(0, 0, 1, 32'hB, 1, 32'h0002_0033);
        cycle(1, 2, 0, 0, 0, 0);
        idle(2);
        chk("R6 fire at zero", 32'(fire_o), 1);
        idle(1);
        chk("R6 reload", count_o, 2);
        idle(2);
        chk("R6 second fire", 32'(fire_o), 1);

        // masked periodic: counting continues, no pulse (R8)
        cycle(0, 0, 0, 0, 1, 32'h0003_0033);
        begin
            int fires = 0;
            for (int i = 0; i < 12; i++) begin
                cycle(0, 0, 0, 0, 0, 0);
                fires += fire_o;
            end
            chk("R8 no pulses", 32'(fires), 0);
        end
        cycle(1, 4, 0, 0, 0, 0);
        idle(1);
        chk("R8 keeps counting", count_o, 3);

        // start value zero (R9)
        cycle(0, 0, 0, 0, 1, 32'h0002_0011);
        cycle(1, 0, 0, 0, 0, 0);
        begin
            int fires = 0;
            for (int i = 0; i < 10; i++) begin
                cycle(0, 0, 0, 0, 0, 0);
                fires += fire_o;
            end
            chk("R9 no pulses", 32'(fires), 0);
            chk("R9 count zero", count_o, 0);
        end

        // entry bit filtering (R10)
        cycle(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        chk("R10 filtered", ent_o, 32'h0003_00FF);

        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            bit wi, wd, we;
            logic [31:0] vi, vd, ve;
            logic [31:0] codes [4];
            codes = '{32'hB, 32'h0, 32'h1, 32'h2};
            wi = ($urandom % 40) == 0;
            wd = ($urandom % 60) == 0;
            we = ($urandom % 50) == 0;
            vi = ($urandom % 8 == 0) ? 0 : ($urandom % 12) + 1;
            vd = ($urandom % 10 == 0) ? $urandom : (codes[$urandom % 4] | ($urandom & 32'hFFFF_FFF4));
            ve = $urandom;
            cycle(wi, vi, wd, vd, we, ve);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule